// File: doc/BRIEF.md
# Timer Channel Status and Control Bank

This block holds the status and control byte of six timer channels behind a simple byte-wide register bus. Each channel watches one input pin. The pin passes through a two-flop synchroniser, and a change between two successive synchronised samples is an edge. Each channel has a two-bit edge selector that picks rising edges, falling edges, both, or none. A selected edge sets the channel's event flag. An interrupt enable bit gates that flag onto a per-channel interrupt request line.

Software clears a flag with an interlocked sequence. First it reads the byte while the flag is set, which arms the clear. Then it writes 0 to the flag bit. Any edge event that lands between the arming read and the clearing write cancels the clear, so no request is lost. The mode-select pair and the edge-select pair are write-protected. They take new values only while the global protection-disable input is high. The interrupt enable bit can always be written.

The counter, compare/PWM outputs and capture latching live elsewhere. This block supplies only the register state, the flags and the interrupt lines.

Top module: `tcs_bank`

## Requirements
- R1: Channel i (i = 0..5) decodes at byte address 0x05 + 3·i, which gives 0x05, 0x08, 0x0B, 0x0E, 0x11 and 0x14. Every other address reads 0x00, and writes to it change no channel.
- R2: The channel byte holds the event flag in bit 7, the interrupt enable in bit 6, the mode-select pair in bits 5:4 and the edge-select pair in bits 3:2. Bits 1:0 always read 0.
- R3: After reset every channel byte reads 0x00 and every interrupt request is low.
- R4: A pin change reaches the flag through two synchroniser flops and one edge register. With the pin changed just before clock edge k, the flag reads 0 after edge k+1 and reads 1 after edge k+2.
- R5: The edge-select code (bit 3, bit 2) chooses the events: 01 means rising edges only, 10 means falling edges only, 11 means both edges.
- R6: With edge-select code 00 the pin is disabled, and no pin activity sets the flag.
- R7: Writing 1 to the flag bit does not set the flag and does not clear it.
- R8: A read of the byte while the flag is set, followed by a write with bit 7 = 0, clears the flag.
- R9: A write with bit 7 = 0 leaves the flag set when no arming read came before it. Any write to the byte drops the arming.
- R10: A selected edge event between the arming read and the clearing write cancels the clear, and the flag stays set.
- R11: Bits 5:2 take the written value only while the protection-disable input is 1; otherwise they keep their value. Bit 6 is written regardless.
- R12: A channel's interrupt request is high exactly when its flag and its interrupt enable are both 1. With the enable at 0, the flag can still be read.
- R13: When a selected edge event and a clearing write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_dis | input | 1 | Global protection disable; 1 allows writes to bits 5:2 |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe, sampled on the clock edge, used for arming |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ch_pin | input | 6 | Channel input pins, asynchronous |
| ch_irq | output | 6 | Per-channel interrupt requests |

## Verification
The hardest case to reach is a flag-setting edge that lands exactly in the cycle of the clearing write. The bench reaches it by toggling the pin on the same falling clock edge as the arming read. It then counts the synchroniser latency and places the write strobe so that the write is sampled on the same rising edge that sees the edge event. The interrupted-clear case is easier to produce: an arming read, a pin toggle with enough settling cycles, and then the write. A sweep over every channel and every edge-select code covers the edge selection. Another sweep over all 256 addresses covers the decode.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned FLAG_BIT = 7;
    localparam int unsigned IE_BIT   = 6;
    localparam int unsigned MS_HI    = 5;
    localparam int unsigned MS_LO    = 4;
    localparam int unsigned ES_HI    = 3;
    localparam int unsigned ES_LO    = 2;

    // edge-select code: bit 1 = falling, bit 0 = rising
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic       ie;
        logic [1:0] ms;
        logic [1:0] es;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] pack_byte(input logic flag, input ctrl_t c);
        return {flag, c.ie, c.ms, c.es, 2'b00};
    endfunction

endpackage

// File: rtl/tcs_pin_sync.sv
module tcs_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t s_d, s_q;
    logic     level;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                s_d      = s_q;
                s_d.sh   = pin_i;
                s_d.prev = s_q.sh[0];
            end
        end else begin : g_chain
            always_comb begin
                s_d      = s_q;
                s_d.sh   = {s_q.sh[STAGES-2:0], pin_i};
                s_d.prev = s_q.sh[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level  = s_q.sh[STAGES-1];
    assign rise_o = level & ~s_q.prev;
    assign fall_o = ~level & s_q.prev;

    // R4
    edge_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |=> (s_q.prev != $past(s_q.prev)));

endmodule

// File: rtl/tcs_chan.sv
module tcs_chan
    import tcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [BYTE_W-1:2]    wdata_i,
    input  logic                 wp_dis_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    output logic [BYTE_W-1:0]    rdata_o,
    output logic                 irq_o
);

    typedef struct packed {
        logic  flag;
        logic  arm;
        ctrl_t c;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     ev;
    logic     wr_here;
    logic     rd_here;
    logic     clr_req;

    always_comb begin
        ev      = (rise_i & s_q.c.es[0]) | (fall_i & s_q.c.es[1]);
        wr_here = hit_i & wr_i;
        rd_here = hit_i & rd_i;
        clr_req = wr_here & s_q.arm & ~wdata_i[FLAG_BIT];

        s_d = s_q;

        if (wr_here) begin
            s_d.c.ie = wdata_i[IE_BIT];
            if (wp_dis_i) begin
                s_d.c.ms = wdata_i[MS_HI:MS_LO];
                s_d.c.es = wdata_i[ES_HI:ES_LO];
            end
        end

        if (ev || wr_here)             s_d.arm = 1'b0;
        else if (rd_here && s_q.flag)  s_d.arm = 1'b1;

        if (ev)           s_d.flag = 1'b1;
        else if (clr_req) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o = pack_byte(s_q.flag, s_q.c);
    assign irq_o   = s_q.flag & s_q.c.ie;

    // R5
    ev_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> s_q.flag);

    // R6
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.c.es == EDGE_OFF) |=> !$rose(s_q.flag));

    // R9
    no_blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !s_q.arm && wr_here) |=> s_q.flag);

    // R11
    prot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_here && !wp_dis_i) |=> ($stable(s_q.c.ms) && $stable(s_q.c.es)));

    // R7
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.flag && !ev) |=> !s_q.flag);

endmodule

// File: rtl/tcs_bank.sv
module tcs_bank
    import tcs_pkg::*;
#(
    parameter int unsigned N_CH        = 6,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BASE_OFF    = 5,
    parameter int unsigned STRIDE      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wp_dis,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [BYTE_W-1:0]    bus_rdata,
    input  logic [N_CH-1:0]      ch_pin,
    output logic [N_CH-1:0]      ch_irq
);

    localparam int unsigned LAST_OFF = BASE_OFF + STRIDE * (N_CH - 1);

    logic [N_CH-1:0]              hit;
    logic [N_CH-1:0]              rise;
    logic [N_CH-1:0]              fall;
    logic [N_CH-1:0][BYTE_W-1:0]  rd_byte;
    logic                         unused_low;

    assign unused_low = ^bus_wdata[1:0];

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            assign hit[i] = (bus_addr == ADDR_W'(BASE_OFF + STRIDE * i));

            tcs_pin_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (ch_pin[i]),
                .rise_o (rise[i]),
                .fall_o (fall[i])
            );

            tcs_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .hit_i    (hit[i]),
                .rd_i     (bus_rd),
                .wr_i     (bus_wr),
                .wdata_i  (bus_wdata[BYTE_W-1:2]),
                .wp_dis_i (wp_dis),
                .rise_i   (rise[i]),
                .fall_i   (fall[i]),
                .rdata_o  (rd_byte[i]),
                .irq_o    (ch_irq[i])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            bus_rdata = bus_rdata | (rd_byte[i] & {BYTE_W{hit[i]}});
        end
    end

    // R1
    decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R1
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > LAST_OFF) |-> (bus_rdata == '0));

    // R2
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[1:0] == 2'b00);

endmodule

// File: tb/tb_tcs_bank.sv
module tb_tcs_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_dis = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] ch_pin = '0;
    logic [5:0] ch_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tcs_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_dis    (wp_dis),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_pin    (ch_pin),
        .ch_irq    (ch_irq)
    );

    function automatic logic [7:0] ch_addr(input int i);
        return 8'(5 + 3 * i);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_flag(input int ch, input logic [7:0] ctrl);
        logic [7:0] tmp;
        rd(ch_addr(ch), tmp);
        wr(ch_addr(ch), ctrl & 8'h7C);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] ctrl;
        logic [7:0] exp;
        logic [4:0] pat [6];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        for (int i = 0; i < 6; i++) begin
            peek(ch_addr(i), v);
            chk("R3 reset byte", v, 8'h00);
        end
        chk("R3 reset irq", {2'b00, ch_irq}, 8'h00);

        // R1 / R2 / R7: address map and byte layout
        wp_dis = 1'b1;
        for (int i = 0; i < 6; i++) begin
            pat[i] = 5'((i * 5 + 3) % 32);
            wr(ch_addr(i), {1'b1, pat[i], 2'b11});
        end
        for (int a = 0; a < 256; a++) begin
            bit mapped = 1'b0;
            for (int i = 0; i < 6; i++) if (a == 5 + 3 * i) mapped = 1'b1;
            if (!mapped) wr(8'(a), 8'hFC);
        end
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            exp = 8'h00;
            for (int i = 0; i < 6; i++) if (a == 5 + 3 * i) exp = {1'b0, pat[i], 2'b00};
            peek(8'(a), v);
            chk("R1 R2 R7 map readback", v, exp);
        end
        for (int i = 0; i < 6; i++) wr(ch_addr(i), 8'h00);
        chk("R12 irq after setup", {2'b00, ch_irq}, 8'h00);

        // R5 / R6 / R8: every channel, every edge-select code
        for (int ch = 0; ch < 6; ch++) begin
            for (int es = 0; es < 4; es++) begin
                ctrl = {4'b0000, 2'(es), 2'b00};
                wr(ch_addr(ch), ctrl);
                ch_pin[ch] = 1'b1;
                settle();
                peek(ch_addr(ch), v);
                exp = {(es % 2 == 1), 7'(ctrl[6:0])};
                chk((es == 0) ? "R6 rising with pin off" : "R5 rising edge", v, exp);
                if (v[7]) begin
                    clear_flag(ch, ctrl);
                    peek(ch_addr(ch), v);
                    chk("R8 clear after rise", v, ctrl);
                end
                ch_pin[ch] = 1'b0;
                settle();
                peek(ch_addr(ch), v);
                exp = {(es >= 2), 7'(ctrl[6:0])};
                chk((es == 0) ? "R6 falling with pin off" : "R5 falling edge", v, exp);
                if (v[7]) clear_flag(ch, ctrl);
            end
            wr(ch_addr(ch), 8'h00);
        end

        // R4: latency from pin to flag
        wr(ch_addr(2), 8'h04);
        @(negedge clk);
        ch_pin[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        peek(ch_addr(2), v);
        chk("R4 flag not yet set after two edges", v, 8'h04);
        @(negedge clk);
        peek(ch_addr(2), v);
        chk("R4 flag set after third edge", v, 8'h84);

        // R9 / R7: writes without arming
        wr(ch_addr(2), 8'h04);
        peek(ch_addr(2), v);
        chk("R9 unarmed write leaves flag", v, 8'h84);
        rd(ch_addr(2), v);
        wr(ch_addr(2), 8'h84);
        peek(ch_addr(2), v);
        chk("R7 write one keeps flag", v, 8'h84);
        wr(ch_addr(2), 8'h04);
        peek(ch_addr(2), v);
        chk("R9 arming dropped by write", v, 8'h84);
        clear_flag(2, 8'h04);
        peek(ch_addr(2), v);
        chk("R8 proper clear", v, 8'h04);

        // R10: event between read and write
        wr(ch_addr(3), 8'h0C);
        ch_pin[3] = 1'b1;
        settle();
        rd(ch_addr(3), v);
        ch_pin[3] = 1'b0;
        settle();
        wr(ch_addr(3), 8'h0C);
        peek(ch_addr(3), v);
        chk("R10 intervening event keeps flag", v, 8'h8C);
        clear_flag(3, 8'h0C);
        peek(ch_addr(3), v);
        chk("R10 later clear works", v, 8'h0C);

        // R13: event and clearing write in the same cycle
        wr(ch_addr(4), 8'h0C);
        ch_pin[4] = 1'b1;
        settle();
        @(negedge clk);
        ch_pin[4] = 1'b0;
        bus_addr = ch_addr(4);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        bus_wdata = 8'h0C;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        peek(ch_addr(4), v);
        chk("R13 set wins over clear", v, 8'h8C);
        clear_flag(4, 8'h0C);
        peek(ch_addr(4), v);
        chk("R13 flag clearable afterwards", v, 8'h0C);

        // R11: write protection
        wp_dis = 1'b0;
        wr(ch_addr(5), 8'hFC);
        peek(ch_addr(5), v);
        chk("R11 protected write", v, 8'h40);
        wp_dis = 1'b1;
        wr(ch_addr(5), 8'h3C);
        peek(ch_addr(5), v);
        chk("R11 unprotected write", v, 8'h3C);
        wp_dis = 1'b0;
        wr(ch_addr(5), 8'h40);
        peek(ch_addr(5), v);
        chk("R11 enable writable under protection", v, 8'h7C);

        // R12: interrupt gating
        ch_pin[5] = 1'b1;
        settle();
        chk("R12 irq raised", {2'b00, ch_irq}, 8'h20);
        wr(ch_addr(5), 8'h00);
        peek(ch_addr(5), v);
        chk("R12 flag polled with enable off", v, 8'hBC);
        chk("R12 irq masked", {2'b00, ch_irq}, 8'h00);
        wr(ch_addr(5), 8'h40);
        chk("R12 irq back", {2'b00, ch_irq}, 8'h20);
        clear_flag(5, 8'h7C);
        chk("R12 irq after clear", {2'b00, ch_irq}, 8'h00);

        finish_run();
    end

endmodule